// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The RAM has two byte lanes. The block takes one single-word read or write request at a time. It turns each request into a control sequence that meets the RAM's access, pulse and bus-release limits. Each phase length is a whole number of clocks, worked out at elaboration from nanosecond parameters and a clock-period parameter.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While an operation is in progress, `req_ready` stays low, and a host that holds `req_valid` high is simply held back.

Read data comes back as a one-clock pulse on `rd_valid` with no back-pressure, so the host must take the word in that cycle. On the memory side, the RAM data bus is split into three signals: an outgoing word, a drive enable and an incoming word.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, chip enable, write enable, output enable and both byte selects are high (inactive), the data drive enable is low and `rd_valid` is low. The first cycle after reset is idle with `req_ready` high.
- R2: `req_ready` is high only in the idle state, and all strobes are high in every cycle where it is high. A request is accepted only on an edge where `req_valid` and `req_ready` are both high.
- R3: A write is one setup clock followed by a strobe phase, and the whole sequence uses the captured mask. In the setup clock, chip enable is low and write enable is high. In the strobe phase, write enable is low for WR = max(ceil(pulse/period), ceil((release+setup)/period)) clocks, which is 6 at an 8 ns clock. Mask bit 0 enables the lower select (`mem_bsel_n[0]`, data bits 7:0) and mask bit 1 enables the upper select (`mem_bsel_n[1]`, bits 15:8). A lane is selected when its mask bit is 1, and its select pin is then low.
- R4: Output enable is high for the whole write. The data drivers are enabled only in cycles where write enable is low, and they carry the captured write word.
- R5: The memory address changes only while chip enable is high. It holds the captured request address for every cycle in which chip enable is low.
- R6: A read holds chip enable and output enable low and write enable high for RD = max(ceil(address access/period), ceil(output-enable access/period)) clocks, which is 7 at an 8 ns clock. The byte selects follow the captured mask.
- R7: The read word is sampled at the edge that ends the last read clock. `rd_valid` is high for exactly the following clock, and `rd_data` then carries the sampled word.
- R8: After every operation there is exactly one turnaround clock with all strobes high and `req_ready` low. Idle follows it, with `req_ready` high again.
- R9: A write leaves every deselected byte lane of the addressed word unchanged. Reading back with both lanes selected returns the new bytes in the written lanes and the old bytes in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller ready to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Byte-lane enables, bit 0 lower, bit 1 upper |
| rd_valid | output | 1 | Read word valid (one-clock pulse) |
| rd_data | output | 16 | Read word |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_bsel_n | output | 2 | RAM byte selects, active low, bit 0 lower lane |
| mem_dout | output | 16 | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data from the RAM |

## Verification
A finishing read's `rd_valid` pulse and a pending host request both land in the turnaround cycle. At the end of that cycle the controller must deliver the word and also refuse the waiting request.

The bench provokes this by issuing reads and writes back to back while holding `req_valid` high throughout. A per-cycle reference model checks several things on every clock. The pulse and the data must appear in exactly the turnaround cycle. `req_ready` must stay low in that cycle. The next request must be taken only one clock later. The bench's RAM model returns a garbage word until the access time has elapsed, so an early sample is caught.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WSTROBE,
    ST_RDACC,
    ST_TURN
  } asram_state_e;

  // clocks needed to cover a time limit
  function automatic int ns_to_clk(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

  // R3 R6: phase counter steps down by one per clock
  tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_lane_sel.sv
module asram_lane_sel #(
  parameter int LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] sel_n
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel_n[i] = ~(active & lane_en[i]);
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WP_NS  = 45,
  parameter int T_WHZ_NS = 20,
  parameter int T_DW_NS  = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_mask,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [DATA_W/8-1:0]     mem_bsel_n,
  output logic [DATA_W-1:0]       mem_dout,
  output logic                    mem_dout_en,
  input  logic [DATA_W-1:0]       mem_din
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_OE_NS, CLK_NS));
  localparam int WR_CYC = imax(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_WHZ_NS + T_DW_NS, CLK_NS));
  localparam int CNT_W  = $clog2(imax(RD_CYC, WR_CYC) + 1);

  asram_state_e       state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   mask_q;
  logic               cnt_zero;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_val;
  logic               accept;
  logic               busy;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  assign cnt_load = (accept && !req_write) || (state_q == ST_WSETUP);
  assign cnt_val  = (state_q == ST_WSETUP) ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);

  asram_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .cnt_zero (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          state_q <= req_write ? ST_WSETUP : ST_RDACC;
        end
        ST_WSETUP:  state_q <= ST_WSTROBE;
        ST_WSTROBE: if (cnt_zero) state_q <= ST_TURN;
        ST_RDACC: if (cnt_zero) begin
          rd_data  <= mem_din;
          rd_valid <= 1'b1;
          state_q  <= ST_TURN;
        end
        ST_TURN:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q == ST_WSETUP) || (state_q == ST_WSTROBE) || (state_q == ST_RDACC);
  assign mem_ce_n    = ~busy;
  assign mem_we_n    = (state_q != ST_WSTROBE);
  assign mem_oe_n    = (state_q != ST_RDACC);
  assign mem_dout_en = (state_q == ST_WSTROBE);
  assign mem_dout    = wdata_q;
  assign mem_addr    = addr_q;

  asram_lane_sel #(.LANES(LANES)) i_lanes (
    .active  (busy),
    .lane_en (mask_q),
    .sel_n   (mem_bsel_n)
  );

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (!mem_we_n && mem_oe_n));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R6
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R7
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  turn_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int PER   = 8;
  localparam int RD_EX = (55 + PER - 1) / PER;
  localparam int WR_EX = ((45 + PER - 1) / PER > (45 + PER - 1) / PER) ? 0 : (45 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_bsel_n;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din;

  always #(PER/2) clk = ~clk;

  asram_ctrl #(.CLK_NS(PER)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bsel_n(mem_bsel_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- RAM model (address low byte indexes the array)
  logic [15:0] ram [0:255];
  int          act_cnt = 0;
  initial for (int i = 0; i < 256; i++) ram[i] = 16'h0000;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) act_cnt <= act_cnt + 1;
    else act_cnt <= 0;
    if (rst_n && !mem_ce_n && !mem_we_n) begin
      if (!mem_bsel_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
      if (!mem_bsel_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dout[15:8];
    end
  end

  always_comb begin
    mem_din = 16'h0000;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (act_cnt < RD_EX - 1) mem_din = 16'hDEAD;
      else begin
        if (!mem_bsel_n[0]) mem_din[7:0]  = ram[mem_addr[7:0]][7:0];
        if (!mem_bsel_n[1]) mem_din[15:8] = ram[mem_addr[7:0]][15:8];
      end
    end
  end

  // ---------------- reference model: queue of expected cycles
  // entry: [8:7] kind (0 write, 1 read, 2 turn), [6] ce_n [5] we_n [4] oe_n [3:2] bsel_n [1] den [0] rv
  logic [8:0]  expq [$];
  logic [15:0] shadow [0:255];
  logic [17:0] exp_addr  = '0;
  logic [15:0] exp_wdata = '0;
  logic [15:0] exp_rdata = '0;
  initial for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;

  always @(negedge clk) begin
    logic [6:0] got;
    got = {mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n, mem_dout_en, rd_valid};
    if (!rst_n) begin
      // R1
      chk(got == 7'b1111100, "R1", "strobes in reset", int'(got), 7'b1111100);
      expq.delete();
    end else begin
      if (expq.size() == 0) begin
        // R2 idle cycle
        chk(req_ready == 1'b1, "R2", "ready idle", req_ready, 1);
        chk(got == 7'b1111100, "R2", "idle strobes", int'(got), 7'b1111100);
      end else begin
        logic [8:0] e;
        string tg;
        e  = expq[0];
        tg = (e[8:7] == 2'd0) ? "R3/R4" : (e[8:7] == 2'd1) ? "R6" : "R8";
        chk(req_ready == 1'b0, tg, "ready busy", req_ready, 0);
        chk(got[6:1] == e[6:1], tg, "strobes", int'(got[6:1]), int'(e[6:1]));
        chk(got[0] == e[0], "R7", "rd_valid", got[0], e[0]);
        if (!mem_ce_n) chk(mem_addr == exp_addr, "R5", "address", mem_addr, exp_addr);
        if (mem_dout_en) chk(mem_dout == exp_wdata, "R4", "write data", mem_dout, exp_wdata);
        if (e[0]) chk(rd_data == exp_rdata, "R7/R9", "read data", rd_data, exp_rdata);
        void'(expq.pop_front());
      end
      if (req_valid && req_ready) begin
        logic [1:0] bs;
        bs = ~req_mask;
        exp_addr = req_addr;
        if (req_write) begin
          exp_wdata = req_wdata;
          if (req_mask[0]) shadow[req_addr[7:0]][7:0]  = req_wdata[7:0];
          if (req_mask[1]) shadow[req_addr[7:0]][15:8] = req_wdata[15:8];
          expq.push_back({2'd0, 3'b011, bs, 2'b00});
          for (int k = 0; k < WR_EX; k++) expq.push_back({2'd0, 3'b001, bs, 2'b10});
          expq.push_back({2'd2, 3'b111, 2'b11, 2'b00});
        end else begin
          exp_rdata = {req_mask[1] ? shadow[req_addr[7:0]][15:8] : 8'h00,
                       req_mask[0] ? shadow[req_addr[7:0]][7:0]  : 8'h00};
          for (int k = 0; k < RD_EX; k++) expq.push_back({2'd1, 3'b010, bs, 2'b00});
          expq.push_back({2'd2, 3'b111, 2'b11, 2'b01});
        end
      end
    end
  end

  // ---------------- stimulus
  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic release_req(input int gap);
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 full-word write, R6 R7 readback
    issue(1, 18'h00010, 16'h1234, 2'b11); release_req(2);
    issue(0, 18'h00010, 16'h0000, 2'b11); release_req(3);
    // R9 lower lane only, then upper lane only, then full readback
    issue(1, 18'h00021, 16'hAABB, 2'b01); release_req(1);
    issue(0, 18'h00021, 16'h0000, 2'b11); release_req(1);
    issue(1, 18'h00021, 16'hCCDD, 2'b10); release_req(1);
    issue(0, 18'h00021, 16'h0000, 2'b11); release_req(1);
    // R6 upper-lane-only read
    issue(0, 18'h00010, 16'h0000, 2'b10); release_req(1);
    // R5 R8 back-to-back with request held high across turnarounds
    issue(1, 18'h3FFFF, 16'h5A5A, 2'b11);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    issue(1, 18'h00000, 16'hF00F, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b01);
    issue(1, 18'h00010, 16'h9988, 2'b10);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    release_req(20);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule